// File: doc/BRIEF.md
# Output Divider Pair Search Engine

This block picks the two output dividers of a programmable clock synthesizer for a requested output frequency. The synthesizer has an internal oscillator that must run inside a narrow window, from 4850 to 5670 MHz. The oscillator clock passes through a coarse high-speed divider and then through a finer output divider. Given a target frequency in whole MHz, the engine tests every legal pair of divider ratios. It keeps the pair that places the oscillator inside the window with the smallest overall division. It then reports the register codes for both dividers and the oscillator frequency that results.

Tests run one candidate pair per clock cycle, in a fixed number of cycles. A caller raises `start` while `ready` is high and waits for the one-cycle `done` pulse. If no pair fits, `err` is raised together with `done` and the previous result stays on the outputs. The stage that computes the fractional multiplier afterwards and the serial register transfer are handled elsewhere.

Top module: `divpair_search`

## Requirements
- R1: After a synchronous active-low reset, `ready` is 1, and `done`, `err`, `hs_code`, `n1_code` and `osc_mhz` are all 0.
- R2: `ready` is 1 exactly when the engine is idle. A `start` seen while `ready` is 0 is ignored and does not change the running search or its result.
- R3: `done` is a one-cycle pulse. It is high after the 391st rising edge following the edge that accepted `start`, which is the number of candidates plus one.
- R4: High-speed divider ratios 4, 5, 6, 7, 9 and 11 are reported on `hs_code` as 000, 001, 010, 011, 101 and 111. Codes 100 and 110 never appear.
- R5: The output divider ratio is 1 or an even value from 2 to 128. `n1_code` carries the ratio minus one, so any nonzero code is odd.
- R6: On success, `osc_mhz` equals the target times both ratios and lies from 4850 to 5670 inclusive.
- R7: Among the fitting pairs, the chosen pair has the smallest product of the two ratios. On equal products, the larger high-speed ratio wins. For example, a target of 210 gives ratios 6 and 4.
- R8: When no pair fits, `err` is 1 during the `done` pulse, and `hs_code`, `n1_code` and `osc_mhz` keep their previous values.
- R9: Targets from 970 to 1134 select ratios 5 and 1. Targets from 1213 to 1417 select ratios 4 and 1. Targets of 946, 1212 and 1418 produce an error.
- R10: A successful search after a failed one reports `err` as 0 and updates the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search; accepted only while `ready` is high |
| target | input | 11 | Requested output frequency in MHz |
| ready | output | 1 | Engine idle and able to accept `start` |
| done | output | 1 | One-cycle pulse marking the end of a search |
| err | output | 1 | No legal divider pair fits; valid with `done` and held afterwards |
| hs_code | output | 3 | High-speed divider register code |
| n1_code | output | 7 | Output divider register code (ratio minus one) |
| osc_mhz | output | 23 | Oscillator frequency of the selected pair in MHz |

## Verification
The hardest condition to reach from the ports is a `start` that arrives in the middle of a search with a different target. The engine must ignore it completely. The stimulus therefore pulses `start` with an altered target partway through several searches, and checks that the result still matches the first target.

Error outcomes right after successful ones are also uncommon under random targets. Directed targets on both sides of each band edge produce failed searches followed by successful ones, so the hold and recovery behaviour is exercised. A bench model of the pair search that walks the pairs in a different order checks the tie-break.

// File: rtl/divpair_pkg.sv
// Shared constants, state type and divider decode helpers for the search engine.
// Assumes six legal high-speed ratios indexed 0..5 in ascending order.
package divpair_pkg;
    localparam int HS_NUM = 6;
    localparam int HS_RW  = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} state_t;

    // Ratio of the high-speed divider for a candidate index.
    function automatic logic [HS_RW-1:0] hs_ratio_of(input logic [2:0] idx);
        case (idx)
            3'd0:    return 4'd4;
            3'd1:    return 4'd5;
            3'd2:    return 4'd6;
            3'd3:    return 4'd7;
            3'd4:    return 4'd9;
            default: return 4'd11;
        endcase
    endfunction

    // Register code of the high-speed divider; codes 100 and 110 are skipped.
    function automatic logic [2:0] hs_code_of(input logic [2:0] idx);
        case (idx)
            3'd4:    return 3'b101;
            3'd5:    return 3'b111;
            default: return idx;
        endcase
    endfunction
endpackage

// File: rtl/divpair_walker.sv
// Steps through every candidate pair, one per cycle: output ratio inner, high-speed outer.
// Assumes clear and step are never high together.
module divpair_walker
    import divpair_pkg::*;
#(
    parameter int N1_LOG = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                step,
    output logic [2:0]          hs_idx,
    output logic [HS_RW-1:0]    hs_ratio,
    output logic [2:0]          hs_code,
    output logic [N1_LOG:0]     n1_ratio,
    output logic                last
);
    localparam int N1_CNT = (1 << (N1_LOG - 1)) + 1;
    localparam logic [N1_LOG-1:0] N1_LAST = N1_LOG'(N1_CNT - 1);
    localparam logic [2:0] HS_LAST = 3'(HS_NUM - 1);

    logic [N1_LOG-1:0] n1_idx;

    // Advance the candidate indices, wrapping the inner index into the outer one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hs_idx <= '0;
            n1_idx <= '0;
        end else if (step) begin
            if (n1_idx == N1_LAST) begin
                n1_idx <= '0;
                hs_idx <= (hs_idx == HS_LAST) ? 3'd0 : hs_idx + 3'd1;
            end else begin
                n1_idx <= n1_idx + 1'b1;
            end
        end
    end

    // Decode the indices into ratios and the register code.
    always_comb begin
        hs_ratio = hs_ratio_of(hs_idx);
        hs_code  = hs_code_of(hs_idx);
        n1_ratio = (n1_idx == '0) ? (N1_LOG+1)'(1) : {n1_idx, 1'b0};
        last     = (hs_idx == HS_LAST) && (n1_idx == N1_LAST);
    end

    // R4
    hs_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_idx <= HS_LAST);
endmodule

// File: rtl/divpair_eval.sv
// Forms the ratio product and the oscillator frequency of one candidate and tests the window.
// Purely combinational; assumes the target is stable during a search.
module divpair_eval
    import divpair_pkg::*;
#(
    parameter int TGT_W  = 11,
    parameter int N1_LOG = 7,
    parameter int FMIN   = 4850,
    parameter int FMAX   = 5670
) (
    input  logic [TGT_W-1:0]              target,
    input  logic [HS_RW-1:0]              hs_ratio,
    input  logic [N1_LOG:0]               n1_ratio,
    output logic [HS_RW+N1_LOG:0]         prod,
    output logic [TGT_W+HS_RW+N1_LOG:0]   osc,
    output logic                          fit
);
    localparam int PROD_W = HS_RW + N1_LOG + 1;
    localparam int OSC_W  = TGT_W + PROD_W;

    // Multiply out the candidate and compare against the inclusive window.
    always_comb begin
        prod = PROD_W'(hs_ratio) * PROD_W'(n1_ratio);
        osc  = OSC_W'(target) * OSC_W'(prod);
        fit  = (osc >= OSC_W'(FMIN)) && (osc <= OSC_W'(FMAX));
    end
endmodule

// File: rtl/divpair_keeper.sv
// Holds the best fitting candidate seen so far: smallest product, then larger high-speed ratio.
// Assumes clear is pulsed at the start of each search.
module divpair_keeper
    import divpair_pkg::*;
#(
    parameter int N1_LOG = 7,
    parameter int PROD_W = 12,
    parameter int OSC_W  = 23
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                en,
    input  logic                fit,
    input  logic [PROD_W-1:0]   prod,
    input  logic [HS_RW-1:0]    hs_ratio,
    input  logic [2:0]          hs_code,
    input  logic [N1_LOG:0]     n1_ratio,
    input  logic [OSC_W-1:0]    osc,
    output logic                found,
    output logic [2:0]          best_hs_code,
    output logic [N1_LOG-1:0]   best_n1_code,
    output logic [OSC_W-1:0]    best_osc
);
    logic [PROD_W-1:0] best_prod;
    logic [HS_RW-1:0]  best_hs;
    logic              better;

    // Decide whether the current candidate beats the stored one.
    always_comb begin
        better = fit && (!found || (prod < best_prod) ||
                         ((prod == best_prod) && (hs_ratio > best_hs)));
    end

    // Record the winning candidate.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            found        <= 1'b0;
            best_prod    <= '0;
            best_hs      <= '0;
            best_hs_code <= '0;
            best_n1_code <= '0;
            best_osc     <= '0;
        end else if (en && better) begin
            found        <= 1'b1;
            best_prod    <= prod;
            best_hs      <= hs_ratio;
            best_hs_code <= hs_code;
            best_n1_code <= N1_LOG'(n1_ratio - 1'b1);
            best_osc     <= osc;
        end
    end

    // R7
    keep_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !clear) |=> (best_prod <= $past(best_prod)));
endmodule

// File: rtl/divpair_search.sv
// Top of the divider pair search: start/ready handshake, candidate scan, result registers.
// Assumes target is only sampled when start is accepted; the search takes a fixed cycle count.
module divpair_search
    import divpair_pkg::*;
#(
    parameter int TGT_W  = 11,
    parameter int N1_LOG = 7,
    parameter int FMIN   = 4850,
    parameter int FMAX   = 5670
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [TGT_W-1:0]                  target,
    output logic                              ready,
    output logic                              done,
    output logic                              err,
    output logic [2:0]                        hs_code,
    output logic [N1_LOG-1:0]                 n1_code,
    output logic [TGT_W+HS_RW+N1_LOG:0]       osc_mhz
);
    localparam int PROD_W = HS_RW + N1_LOG + 1;
    localparam int OSC_W  = TGT_W + PROD_W;

    state_t             state;
    logic [TGT_W-1:0]   tgt_q;
    logic               accept;
    logic               scanning;
    logic [2:0]         c_hs_idx;
    logic [HS_RW-1:0]   c_hs_ratio;
    logic [2:0]         c_hs_code;
    logic [N1_LOG:0]    c_n1_ratio;
    logic               c_last;
    logic [PROD_W-1:0]  c_prod;
    logic [OSC_W-1:0]   c_osc;
    logic               c_fit;
    logic               b_found;
    logic [2:0]         b_hs_code;
    logic [N1_LOG-1:0]  b_n1_code;
    logic [OSC_W-1:0]   b_osc;

    // Handshake decode.
    always_comb begin
        ready    = (state == ST_IDLE);
        accept   = ready && start;
        scanning = (state == ST_SCAN);
    end

    divpair_walker #(.N1_LOG(N1_LOG)) u_walk (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(scanning),
        .hs_idx(c_hs_idx), .hs_ratio(c_hs_ratio), .hs_code(c_hs_code),
        .n1_ratio(c_n1_ratio), .last(c_last)
    );

    divpair_eval #(.TGT_W(TGT_W), .N1_LOG(N1_LOG), .FMIN(FMIN), .FMAX(FMAX)) u_eval (
        .target(tgt_q), .hs_ratio(c_hs_ratio), .n1_ratio(c_n1_ratio),
        .prod(c_prod), .osc(c_osc), .fit(c_fit)
    );

    divpair_keeper #(.N1_LOG(N1_LOG), .PROD_W(PROD_W), .OSC_W(OSC_W)) u_keep (
        .clk(clk), .rst_n(rst_n), .clear(accept), .en(scanning), .fit(c_fit),
        .prod(c_prod), .hs_ratio(c_hs_ratio), .hs_code(c_hs_code),
        .n1_ratio(c_n1_ratio), .osc(c_osc), .found(b_found),
        .best_hs_code(b_hs_code), .best_n1_code(b_n1_code), .best_osc(b_osc)
    );

    // Sequence the search and publish the result on the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tgt_q   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            hs_code <= '0;
            n1_code <= '0;
            osc_mhz <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    tgt_q <= target;
                    state <= ST_SCAN;
                end
                ST_SCAN: if (c_last) state <= ST_FIN;
                default: begin
                    done  <= 1'b1;
                    err   <= !b_found;
                    state <= ST_IDLE;
                    if (b_found) begin
                        hs_code <= b_hs_code;
                        n1_code <= b_n1_code;
                        osc_mhz <= b_osc;
                    end
                end
            endcase
        end
    end

    // R2
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && start) |=> $stable(tgt_q));
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    legal_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code != 3'b100) && (hs_code != 3'b110));
    // R5
    n1_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n1_code == '0) || n1_code[0]);
    // R6
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((osc_mhz >= OSC_W'(FMIN)) && (osc_mhz <= OSC_W'(FMAX))));
    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($stable(hs_code) && $stable(n1_code) && $stable(osc_mhz)));
endmodule

// File: tb/sim_divpair_search.sv
// Bench: directed band-edge targets plus seeded random targets, checked against a reference search.
module sim_divpair_search;
    localparam int CLK_PERIOD = 10;
    localparam int NCAND = 6 * 65;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] target = '0;
    logic        ready, done, err;
    logic [2:0]  hs_code;
    logic [6:0]  n1_code;
    logic [22:0] osc_mhz;

    int total = 0;
    int bad = 0;
    int exp_hs = 0;
    int exp_n1 = 0;
    int exp_osc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    divpair_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .target(target),
        .ready(ready), .done(done), .err(err),
        .hs_code(hs_code), .n1_code(n1_code), .osc_mhz(osc_mhz)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int hs_enc(input int r);
        case (r)
            4: return 0; 5: return 1; 6: return 2; 7: return 3;
            9: return 5; default: return 7;
        endcase
    endfunction

    // Reference: walk output ratios outer, high-speed ratios descending inner.
    function automatic bit ref_search(input int t, output int bh, output int bn);
        int hs_list[6] = '{11, 9, 7, 6, 5, 4};
        int bp = 0;
        bit ok = 0;
        bh = 0; bn = 0;
        for (int k = 0; k <= 64; k++) begin
            int n = (k == 0) ? 1 : 2 * k;
            for (int j = 0; j < 6; j++) begin
                int p = hs_list[j] * n;
                int f = t * p;
                if (f >= 4850 && f <= 5670 &&
                    (!ok || p < bp || (p == bp && hs_list[j] > bh))) begin
                    ok = 1; bp = p; bh = hs_list[j]; bn = n;
                end
            end
        end
        return ok;
    endfunction

    task automatic run_one(input int tgt, input bit poke);
        int cyc;
        int bh, bn;
        bit ok;
        @(negedge clk);
        check("R2 ready before start", int'(ready), 1);
        start = 1'b1;
        target = 11'(tgt);
        @(negedge clk);
        cyc = 1;
        while (!done && cyc < 2000) begin
            if (poke && cyc == 50) begin
                check("R2 ready low while busy", int'(ready), 0);
                start = 1'b1;
                target = 11'(tgt ^ 11'h155);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        // R3 latency: done after edge NCAND+1 following the accepting edge
        check("R3 latency", cyc, NCAND + 2);
        ok = ref_search(tgt, bh, bn);
        if (ok) begin
            exp_hs = hs_enc(bh);
            exp_n1 = bn - 1;
            exp_osc = tgt * bh * bn;
        end
        // R8 / R10 error flag
        check("R8 R10 err", int'(err), ok ? 0 : 1);
        // R4 R7 R9 divider choice, R5 code, R6 frequency
        check("R4 R7 hs_code", int'(hs_code), exp_hs);
        check("R5 R7 n1_code", int'(n1_code), exp_n1);
        check("R6 osc_mhz", int'(osc_mhz), exp_osc);
        @(negedge clk);
        check("R3 single pulse", int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", int'(ready), 1);
        check("R1 done", int'(done), 0);
        check("R1 err", int'(err), 0);
        check("R1 hs_code", int'(hs_code), 0);
        check("R1 n1_code", int'(n1_code), 0);
        check("R1 osc", int'(osc_mhz), 0);
        rst_n = 1'b1;

        run_one(0, 0);      // R8 error straight after reset, outputs stay zero
        run_one(10, 0);
        run_one(945, 0);
        run_one(946, 0);    // R9 gap
        run_one(970, 0);    // R9 band of ratios 5 and 1
        run_one(1212, 0);   // R9 gap below top band
        run_one(1134, 1);   // R10 recovery, R2 poke
        run_one(1213, 0);   // R9 band of ratios 4 and 1
        run_one(1417, 0);
        run_one(1418, 0);   // R9 above top band
        run_one(210, 1);    // R7 tie-break gives 6 and 4
        run_one(9, 0);
        for (int i = 0; i < 30; i++) begin
            run_one(int'($urandom_range(1, 1500)), (i % 7) == 3);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule